// File: doc/BRIEF.md
# Serial Adapter Address Decode and Control/Status Logic

This block is the glue logic for an expansion-bus serial adapter. It watches a 10-bit I/O address. A bank of switches sets a base that is aligned to eight bytes. Inside that window, the first four offsets go to an external serial controller as a chip select with two register-select bits. The block itself serves the upper four offsets.

Offset 4 holds a small control register. Its writes drive the data-terminal-ready line and the enable for the DMA request/acknowledge drivers. Its reads return the modem and interrupt status as active-low bits.

A terminal-count latch records the end of a DMA transfer on the selected channel. Software clears it by writing any value to offset 5. The latch shares one interrupt output with the serial controller, and the status byte reports the two sources separately, so one handler can tell which one fired. Bus strobes are synchronous, one-clock qualifiers. Chip select and read data are combinational from the address.

Top module: `sio_glue_top`

## Requirements
- R1: The window base is {base_open_i, 3'b000}, so an open switch (input 1) gives a 1 in address bits 9..3. An address decodes only when port_en_i is 1, addr_i[9:3] equals base_open_i, and the base is at least 0x100. A base below 0x100 decodes nothing.
- R2: For offsets 0 to 3, ctl_cs_o is 1 in the same cycle, and ctl_addr_o carries the offset's two low bits: 0 = channel A data, 1 = channel A control, 2 = channel B data, 3 = channel B control. Otherwise ctl_cs_o is 0 and ctl_addr_o is 0.
- R3: While rst_ni is low, dtr_o is 0, dma_drv_en_o is 0 and the terminal-count latch is clear, with no clock edge needed.
- R4: When iow_i is 1 at offset 4, then from the next rising edge dtr_o follows wdata_i[0] and dma_drv_en_o follows wdata_i[7]. Bits 1 to 6 are discarded.
- R5: When ior_i is 1 at offset 4, rdata_o returns a status byte. Bit 0 is the inverse of dsr_i. Bit 3 is the inverse of ctl_irq_i. Bit 5 is the inverse of the latch. All other bits are 1.
- R6: rd_own_o is 1 exactly when ior_i is 1 at offsets 4 to 7. Reads of offsets 5, 6 and 7, and any cycle where rd_own_o is 0, give rdata_o = 0xFF.
- R7: Writes to offsets 6 and 7, and any write while the window does not decode, leave dtr_o, dma_drv_en_o and the latch unchanged.
- R8: At a rising edge where tc_irq_en_i, tc_i and dack_i[dma_sel_i] are all 1, the latch sets. A terminal count without the acknowledge of the selected channel is ignored. Setting does not depend on the address decode.
- R9: A write of any value to offset 5 clears the latch at the next rising edge. If a set condition occurs at the same edge, the set wins.
- R10: irq_o is 1 exactly when irq_en_i is 1 and either ctl_irq_i or the latch is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Card enable switch, 1 = enabled |
| base_open_i | input | 7 | Base switches for address bits 9..3, 1 = open |
| addr_i | input | 10 | I/O address |
| iow_i | input | 1 | Write strobe qualifier |
| ior_i | input | 1 | Read strobe qualifier |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for offsets 4..7 |
| rd_own_o | output | 1 | Block drives the read data |
| ctl_cs_o | output | 1 | Serial controller chip select |
| ctl_addr_o | output | 2 | Serial controller register select |
| dsr_i | input | 1 | Data set ready, 1 = asserted |
| ctl_irq_i | input | 1 | Serial controller interrupt, 1 = pending |
| dma_sel_i | input | 2 | Selected DMA channel |
| dack_i | input | 4 | DMA acknowledges, one per channel |
| tc_i | input | 1 | DMA terminal count |
| tc_irq_en_i | input | 1 | Terminal-count interrupt option |
| irq_en_i | input | 1 | Interrupt line enable |
| dtr_o | output | 1 | Data terminal ready |
| dma_drv_en_o | output | 1 | DMA request/acknowledge driver enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench aims at the window edges: offsets 3 and 4, offset 7 and the next base, the highest base 0x3F8, and a base below 0x100. A decoder that slices or compares the address wrongly would then select the controller for the wrong offset or answer outside its window. Set and clear are driven into the same edge. So are terminal counts on a channel that is not selected. A latch with the wrong priority would drop a fresh terminal count, and one with no acknowledge qualifier would raise stray interrupts. Writes with the card disabled, or to the two spare offsets, are followed by reads of the status byte and checks of dtr_o and dma_drv_en_o, which exposes any leak into the control register.

// File: rtl/sio_glue_pkg.sv
package sio_glue_pkg;
  localparam int unsigned OFF_CTL   = 4;
  localparam int unsigned OFF_TCCLR = 5;
  localparam int unsigned CTL_SLOTS = 4;

  localparam int unsigned ST_DSR = 0;
  localparam int unsigned ST_IRQ = 3;
  localparam int unsigned ST_TC  = 5;

  localparam int unsigned CR_DTR = 0;
  localparam int unsigned CR_DMA = 7;

  typedef enum logic [1:0] {
    SEL_A_DATA = 2'd0,
    SEL_A_CTRL = 2'd1,
    SEL_B_DATA = 2'd2,
    SEL_B_CTRL = 2'd3
  } ctl_sel_e;
endpackage

// File: rtl/sio_addr_dec.sv
module sio_addr_dec #(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OFF_W    = 3,
  parameter int unsigned MIN_BASE = 'h100,
  localparam int unsigned BASE_W  = ADDR_W - OFF_W,
  localparam int unsigned NSLOT   = 1 << OFF_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_open_i,
  input  logic              port_en_i,
  output logic [NSLOT-1:0]  slot_o
);
  logic base_ok, hit;

  assign base_ok = {base_open_i, {OFF_W{1'b0}}} >= ADDR_W'(MIN_BASE);
  assign hit     = port_en_i && base_ok && (addr_i[ADDR_W-1:OFF_W] == base_open_i);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_o[g] = hit && (addr_i[OFF_W-1:0] == OFF_W'(g));
  end
endmodule

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DTR_BIT = 0,
  parameter int unsigned DMA_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dtr_o,
  output logic              dma_en_o
);
  logic unused_wbits;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dtr_o    <= 1'b0;
      dma_en_o <= 1'b0;
    end else if (we_i) begin
      dtr_o    <= wdata_i[DTR_BIT];
      dma_en_o <= wdata_i[DMA_BIT];
    end
  end
endmodule

// File: rtl/sio_tc_latch.sv
module sio_tc_latch #(
  parameter int unsigned N_CH  = 4,
  localparam int unsigned SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tc_i,
  input  logic [N_CH-1:0]  dack_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic set;
  assign set = arm_i && tc_i && dack_i[sel_i];

  // a new terminal count outranks a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set)    pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end
endmodule

// File: rtl/sio_glue_top.sv
module sio_glue_top
  import sio_glue_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned OFF_W    = 3,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_DMA    = 4,
  parameter int unsigned MIN_BASE = 'h100,
  localparam int unsigned BASE_W  = ADDR_W - OFF_W,
  localparam int unsigned NSLOT   = 1 << OFF_W,
  localparam int unsigned CA_W    = $clog2(CTL_SLOTS),
  localparam int unsigned DSEL_W  = (N_DMA > 1) ? $clog2(N_DMA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic [BASE_W-1:0] base_open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              iow_i,
  input  logic              ior_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_own_o,
  output logic              ctl_cs_o,
  output logic [CA_W-1:0]   ctl_addr_o,
  input  logic              dsr_i,
  input  logic              ctl_irq_i,
  input  logic [DSEL_W-1:0] dma_sel_i,
  input  logic [N_DMA-1:0]  dack_i,
  input  logic              tc_i,
  input  logic              tc_irq_en_i,
  input  logic              irq_en_i,
  output logic              dtr_o,
  output logic              dma_drv_en_o,
  output logic              irq_o
);
  logic [NSLOT-1:0]  slot;
  logic              tc_q;
  logic [DATA_W-1:0] status;

  sio_addr_dec #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MIN_BASE(MIN_BASE)
  ) u_dec (
    .addr_i(addr_i), .base_open_i(base_open_i), .port_en_i(port_en_i), .slot_o(slot)
  );

  assign ctl_cs_o   = |slot[CTL_SLOTS-1:0];
  assign ctl_addr_o = ctl_cs_o ? addr_i[CA_W-1:0] : ctl_sel_e'(SEL_A_DATA);
  assign rd_own_o   = ior_i && |slot[NSLOT-1:CTL_SLOTS];

  sio_ctl_reg #(
    .DATA_W(DATA_W), .DTR_BIT(CR_DTR), .DMA_BIT(CR_DMA)
  ) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(iow_i && slot[OFF_CTL]),
    .wdata_i(wdata_i), .dtr_o(dtr_o), .dma_en_o(dma_drv_en_o)
  );

  sio_tc_latch #(.N_CH(N_DMA)) u_tc (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(tc_irq_en_i), .tc_i(tc_i),
    .dack_i(dack_i), .sel_i(dma_sel_i), .clr_i(iow_i && slot[OFF_TCCLR]),
    .pend_o(tc_q)
  );

  always_comb begin
    status         = '1;
    status[ST_DSR] = ~dsr_i;
    status[ST_IRQ] = ~ctl_irq_i;
    status[ST_TC]  = ~tc_q;
  end

  assign rdata_o = (ior_i && slot[OFF_CTL]) ? status : '1;
  assign irq_o   = irq_en_i && (ctl_irq_i || tc_q);
endmodule

// File: rtl/sio_glue_chk.sv
module sio_glue_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       port_en_i,
  input logic [6:0] base_open_i,
  input logic [9:0] addr_i,
  input logic       iow_i,
  input logic [7:0] wdata_i,
  input logic       ctl_cs_o,
  input logic       rd_own_o,
  input logic       dma_drv_en_o,
  input logic       irq_o,
  input logic       irq_en_i,
  input logic       tc_q,
  input logic       tc_i,
  input logic [3:0] dack_i,
  input logic [1:0] dma_sel_i,
  input logic       tc_irq_en_i
);
  logic in_win, tc_set;
  assign in_win = port_en_i && (base_open_i[6:5] != 2'b00) && (addr_i[9:3] == base_open_i);
  assign tc_set = tc_irq_en_i && tc_i && dack_i[dma_sel_i];

  a_r1_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> !ctl_cs_o && !rd_own_o);

  a_r2_cs_in_low_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cs_o |-> in_win && !addr_i[2]);

  a_r4_dma_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && iow_i && addr_i[2:0] == 3'd4) |=> dma_drv_en_o == $past(wdata_i[7]));

  a_r8_tc_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_set |=> tc_q);

  a_r9_tc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && iow_i && addr_i[2:0] == 3'd5 && !tc_set) |=> !tc_q);

  a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

bind sio_glue_top sio_glue_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_en_i(port_en_i), .base_open_i(base_open_i),
  .addr_i(addr_i), .iow_i(iow_i), .wdata_i(wdata_i), .ctl_cs_o(ctl_cs_o),
  .rd_own_o(rd_own_o), .dma_drv_en_o(dma_drv_en_o), .irq_o(irq_o), .irq_en_i(irq_en_i),
  .tc_q(tc_q), .tc_i(tc_i), .dack_i(dack_i), .dma_sel_i(dma_sel_i), .tc_irq_en_i(tc_irq_en_i)
);

// File: tb/sio_glue_top_bench.sv
`timescale 1ns/1ps
module sio_glue_top_bench;
  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       port_en_i = 1;
  logic [6:0] base_open_i = 7'h60;
  logic [9:0] addr_i = 0;
  logic       iow_i = 0, ior_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  logic       rd_own_o, ctl_cs_o;
  logic [1:0] ctl_addr_o;
  logic       dsr_i = 0, ctl_irq_i = 0;
  logic [1:0] dma_sel_i = 0;
  logic [3:0] dack_i = 0;
  logic       tc_i = 0, tc_irq_en_i = 0, irq_en_i = 0;
  logic       dtr_o, dma_drv_en_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  bit m_dtr = 0, m_dma = 0, m_tc = 0;

  always #2 clk_i = ~clk_i;

  sio_glue_top u_sio_glue_top (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // window decode from the requirements, integer arithmetic
  function automatic int offs();
    int base = int'(base_open_i) * 8;
    int a = int'(addr_i);
    if (!port_en_i || base < 256 || a < base || a >= base + 8) return -1;
    return a - base;
  endfunction

  task automatic compare();
    int o = offs();
    int st;
    if (!rst_ni) begin m_dtr = 0; m_dma = 0; m_tc = 0; end
    st = 255;
    if (dsr_i) st -= 1;
    if (ctl_irq_i) st -= 8;
    if (m_tc) st -= 32;
    chk("R2 ctl_cs_o", ctl_cs_o, (o >= 0 && o < 4));
    chk("R2 ctl_addr_o", ctl_addr_o, (o >= 0 && o < 4) ? o : 0);
    chk("R6 rd_own_o", rd_own_o, (ior_i && o >= 4));
    chk("R5 rdata_o", rdata_o, (ior_i && o == 4) ? st : 255);
    chk("R4 dtr_o", dtr_o, m_dtr);
    chk("R4 dma_drv_en_o", dma_drv_en_o, m_dma);
    chk("R10 irq_o", irq_o, irq_en_i && (ctl_irq_i || m_tc));
  endtask

  task automatic advance();
    int o = offs();
    bit set;
    set = tc_irq_en_i && tc_i && dack_i[dma_sel_i];
    @(posedge clk_i);
    if (rst_ni) begin
      if (iow_i && o == 4) begin m_dtr = wdata_i[0]; m_dma = wdata_i[7]; end
      if (set) m_tc = 1;
      else if (iow_i && o == 5) m_tc = 0;
    end
    @(negedge clk_i);
  endtask

  task automatic cyc();
    #1 compare();
    advance();
  endtask

  task automatic idle();
    iow_i = 0; ior_i = 0; tc_i = 0; dack_i = 0;
  endtask

  task automatic wr(input int a, input int d);
    addr_i = 10'(a); wdata_i = 8'(d); iow_i = 1; ior_i = 0; cyc(); idle();
  endtask

  task automatic rd(input int a);
    addr_i = 10'(a); ior_i = 1; iow_i = 0; cyc(); idle();
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R3: reset state, write during reset ignored
    addr_i = 10'h304; wdata_i = 8'hFF; iow_i = 1; cyc(); idle();
    chk("R3 dtr_o in reset", dtr_o, 0);
    chk("R3 dma_drv_en_o in reset", dma_drv_en_o, 0);
    rst_ni = 1; cyc();
    // R1/R2: controller offsets at base 0x300
    for (int i = 0; i < 8; i++) rd(32'h300 + i);
    // R4: control register
    wr(32'h304, 8'h81); rd(32'h304);
    chk("R4 dtr set", dtr_o, 1);
    wr(32'h304, 8'h7E); rd(32'h304);
    chk("R4 middle bits dropped", {dtr_o, dma_drv_en_o}, 0);
    wr(32'h304, 8'h80);
    // R7: spare offsets and disabled card
    wr(32'h306, 8'h01); wr(32'h307, 8'h7F);
    port_en_i = 0; wr(32'h304, 8'h01); rd(32'h304); rd(32'h301); port_en_i = 1;
    chk("R7 dma_drv_en_o kept", dma_drv_en_o, 1);
    // R8: terminal count
    tc_irq_en_i = 1; irq_en_i = 1; dma_sel_i = 2; tc_i = 1; dack_i = 4'b0010; cyc(); idle();
    rd(32'h304);
    tc_i = 1; dack_i = 4'b0100; cyc(); idle(); rd(32'h304);
    chk("R8 latch set", irq_o, 1);
    // R9: clear, then clear with set
    wr(32'h305, 8'h00); rd(32'h304);
    chk("R9 latch cleared", irq_o, 0);
    addr_i = 10'h305; iow_i = 1; tc_i = 1; dack_i = 4'b0100; cyc(); idle(); rd(32'h304);
    chk("R9 set wins", irq_o, 1);
    tc_irq_en_i = 0; tc_i = 1; dack_i = 4'hF; wr(32'h305, 8'h5A); rd(32'h304);
    // R1: low, high and invalid bases
    base_open_i = 7'h7F; for (int i = 0; i < 9; i++) rd(32'h3F7 + i);
    base_open_i = 7'h20; wr(32'h104, 8'h01); rd(32'h103); rd(32'h104); rd(32'h0FF);
    base_open_i = 7'h10; wr(32'h084, 8'h00); rd(32'h080); rd(32'h084);
    chk("R1 base below 0x100 inert", dtr_o, 1);
    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      base_open_i = 7'($urandom_range(16, 127));
      addr_i = 10'(int'(base_open_i) * 8 + int'($urandom_range(0, 11)) - 2);
      iow_i = (r < 30); ior_i = (r >= 30 && r < 70);
      wdata_i = 8'($urandom); port_en_i = ($urandom_range(0, 9) != 0);
      dsr_i = 1'($urandom); ctl_irq_i = 1'($urandom); irq_en_i = 1'($urandom);
      tc_irq_en_i = 1'($urandom); tc_i = ($urandom_range(0, 5) == 0);
      dack_i = 4'($urandom); dma_sel_i = 2'($urandom);
      if (n == 2000) rst_ni = 0;
      if (n == 2003) rst_ni = 1;
      cyc();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule